// File: doc/BRIEF.md
# DSP Immediate Shifter with Status Flags

This unit executes immediate-count arithmetic shifts for a DSP datapath and keeps the status flags those shifts affect. It accepts one operation per cycle, selected by `op_acc_i`. The first kind works on a 16-bit half-word operand. Its 5-bit shift code chooses between a saturating left shift and a sign-filling right shift. The second kind works on a 40-bit accumulator. The accumulator arrives as an 8-bit top part and a 32-bit low word, and it is shifted right arithmetically by an unsigned amount.

Results and flags are captured on the rising clock edge when `valid_i` is high. The flags are zero, negative, overflow, sticky overflow and one overflow bit per accumulator. Each flag has its own write enable, so a flag that an operation does not touch keeps its value. The half-word result register changes only on half-word operations. The accumulator result registers change only on accumulator operations.

Top module: `imm_shift_unit`

## Requirements
- R1: While `rst_n` is low, every flag output and every result output is zero.
- R2: On a half operation, the low 5 bits of `imm_i` form a code m. For m from 17 to 31, the operand is shifted left by 32−m. When there is no overflow, `half_o` is the operand shifted left with zeros filled in, V is cleared, and VS is unchanged.
- R3: On a left shift, overflow occurs when any bit shifted out, or bit 15 of the shifted value, differs from bit 15 of the operand. On overflow, `half_o` is 0x8000 for a negative operand and 0x7FFF for a non-negative one, and V and VS are both set.
- R4: After a left shift, AZ is 1 exactly when `half_o` is zero, and AN equals bit 15 of `half_o`.
- R5: For m from 0 to 16, `half_o` is the operand shifted right arithmetically by m, filled with copies of bit 15. AZ, AN, V, VS and the AV bits keep their values.
- R6: VS is sticky. Once set, it returns to 0 only through reset. A later left shift without overflow clears V and leaves VS at 1.
- R7: On an accumulator operation, the value {`acc_ext_i`,`acc_lo_i`} is shifted right arithmetically from bit 39 by `imm_i[4:0]` (0 to 31). Bits 39:32 of the result go to `acc_ext_o` and bits 31:0 go to `acc_lo_o`.
- R8: After an accumulator operation, AN equals bit 39 of the result and AZ is 1 exactly when all 40 result bits are zero. The AV bit indexed by `acc_sel_i` is 0, and V and VS are unchanged.
- R9: A cycle with `valid_i` low changes no output.
- R10: Bit 5 of `imm_i` has no effect on either operation.
- R11: A half operation leaves `acc_ext_o` and `acc_lo_o` unchanged. An accumulator operation leaves `half_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Perform the operation this cycle |
| op_acc_i | input | 1 | 0 = half-word shift, 1 = accumulator shift |
| acc_sel_i | input | 1 | Index of the accumulator whose AV bit is cleared |
| imm_i | input | 6 | Immediate; bits 4:0 are the shift code or amount |
| half_i | input | 16 | Half-word operand |
| acc_ext_i | input | 8 | Accumulator bits 39:32 |
| acc_lo_i | input | 32 | Accumulator bits 31:0 |
| half_o | output | 16 | Registered half-word result |
| acc_ext_o | output | 8 | Registered accumulator bits 39:32 |
| acc_lo_o | output | 32 | Registered accumulator bits 31:0 |
| flag_az_o | output | 1 | Zero flag |
| flag_an_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_vs_o | output | 1 | Sticky overflow flag |
| flag_av_o | output | 2 | Per-accumulator overflow flags |

## Verification
Several properties are checked on every cycle:
- VS never drops while reset is high.
- V never stands without VS.
- A saturated half result matches the operand's sign.
- AZ and AN agree with the result after every left shift and accumulator shift.
- A right shift of a half-word leaves all flags stable.

Some properties only the directed scenarios can show. These are the exact shifted values, which operands sit at the overflow boundary (lost middle bits with an unchanged sign bit, for example), that bit 5 of the immediate is ignored, and that the two result registers are isolated from each other.

// File: rtl/ishf_pkg.sv
package ishf_pkg;
  typedef enum logic {
    OP_HALF = 1'b0,
    OP_ACC  = 1'b1
  } ishf_op_e;

  typedef struct packed {
    logic az;
    logic an;
    logic v;
    logic vs;
  } ishf_flags_t;
endpackage

// File: rtl/ishf_half_path.sv
module ishf_half_path #(
  parameter int unsigned W      = 16,
  parameter int unsigned CODE_W = 5
) (
  input  logic [W-1:0]      data_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [W-1:0]      res_o,
  output logic              is_left_o,
  output logic              ovf_o
);
  localparam int unsigned SPAN = 2 * W;

  logic [CODE_W-1:0] left_amt;
  logic [W-1:0]      shl_val;
  logic [W-1:0]      shr_val;
  logic [W-1:0]      sat_val;

  always_comb begin
    is_left_o = (code_i > CODE_W'(W));
    left_amt  = CODE_W'(SPAN - int'(code_i));
    shl_val   = data_i << left_amt;
    shr_val   = W'($signed(data_i) >>> code_i);
    sat_val   = data_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    ovf_o     = 1'b0;
    if (is_left_o) begin
      for (int i = 0; i < int'(W) - 1; i++) begin
        if ((i < int'(left_amt)) && (data_i[W-2-i] != data_i[W-1])) ovf_o = 1'b1;
      end
    end
    if (!is_left_o)  res_o = shr_val;
    else if (ovf_o)  res_o = sat_val;
    else             res_o = shl_val;
  end
endmodule

// File: rtl/ishf_acc_path.sv
module ishf_acc_path #(
  parameter int unsigned EXT_W = 8,
  parameter int unsigned LO_W  = 32,
  parameter int unsigned AMT_W = 5
) (
  input  logic [EXT_W-1:0] ext_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [EXT_W-1:0] ext_o,
  output logic [LO_W-1:0]  lo_o,
  output logic             zero_o,
  output logic             neg_o
);
  localparam int unsigned ACC_W = EXT_W + LO_W;

  logic [ACC_W-1:0] shifted;

  always_comb begin
    shifted = ACC_W'($signed({ext_i, lo_i}) >>> amt_i);
    ext_o   = shifted[ACC_W-1:LO_W];
    lo_o    = shifted[LO_W-1:0];
    zero_o  = (shifted == '0);
    neg_o   = shifted[ACC_W-1];
  end
endmodule

// File: rtl/ishf_flag_regs.sv
module ishf_flag_regs
  import ishf_pkg::*;
#(
  parameter int unsigned NUM_ACC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ishf_flags_t         we_i,
  input  ishf_flags_t         val_i,
  input  logic [NUM_ACC-1:0]  av_clr_i,
  output ishf_flags_t         flags_o,
  output logic [NUM_ACC-1:0]  av_o
);
  ishf_flags_t        flags_q, flags_d;
  logic [NUM_ACC-1:0] av_q, av_d;

  always_comb begin
    flags_d    = flags_q;
    if (we_i.az) flags_d.az = val_i.az;
    if (we_i.an) flags_d.an = val_i.an;
    if (we_i.v)  flags_d.v  = val_i.v;
    if (we_i.vs) flags_d.vs = val_i.vs;
  end

  for (genvar g = 0; g < int'(NUM_ACC); g++) begin : g_av
    always_comb av_d[g] = av_clr_i[g] ? 1'b0 : av_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      av_q    <= '0;
    end else begin
      flags_q <= flags_d;
      av_q    <= av_d;
    end
  end

  assign flags_o = flags_q;
  assign av_o    = av_q;

  p_vs_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.vs |=> flags_q.vs)
    else $error("p_vs_sticky_r6");
endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
  import ishf_pkg::*;
#(
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned EXT_W   = 8,
  parameter int unsigned LO_W    = 32,
  parameter int unsigned NUM_ACC = 2,
  parameter int unsigned IMM_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               op_acc_i,
  input  logic               acc_sel_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [HALF_W-1:0]  half_i,
  input  logic [EXT_W-1:0]   acc_ext_i,
  input  logic [LO_W-1:0]    acc_lo_i,
  output logic [HALF_W-1:0]  half_o,
  output logic [EXT_W-1:0]   acc_ext_o,
  output logic [LO_W-1:0]    acc_lo_o,
  output logic               flag_az_o,
  output logic               flag_an_o,
  output logic               flag_v_o,
  output logic               flag_vs_o,
  output logic [NUM_ACC-1:0] flag_av_o
);
  localparam int unsigned CODE_W = $clog2(2 * HALF_W);
  localparam int unsigned ACC_W  = EXT_W + LO_W;

  ishf_op_e          op;
  logic [CODE_W-1:0] code;
  logic              unused_imm_hi;

  assign op            = ishf_op_e'(op_acc_i);
  assign code          = imm_i[CODE_W-1:0];
  assign unused_imm_hi = ^imm_i[IMM_W-1:CODE_W];

  logic [HALF_W-1:0] h_res;
  logic              h_left, h_ovf;
  logic [EXT_W-1:0]  a_ext;
  logic [LO_W-1:0]   a_lo;
  logic              a_zero, a_neg;

  ishf_half_path #(.W(HALF_W), .CODE_W(CODE_W)) u_half (
    .data_i(half_i), .code_i(code), .res_o(h_res),
    .is_left_o(h_left), .ovf_o(h_ovf)
  );

  ishf_acc_path #(.EXT_W(EXT_W), .LO_W(LO_W), .AMT_W(CODE_W)) u_acc (
    .ext_i(acc_ext_i), .lo_i(acc_lo_i), .amt_i(code),
    .ext_o(a_ext), .lo_o(a_lo), .zero_o(a_zero), .neg_o(a_neg)
  );

  // Flag write enables and values
  ishf_flags_t        fl_we, fl_val, fl_q;
  logic [NUM_ACC-1:0] av_clr;
  logic               half_en, acc_en;

  always_comb begin
    half_en = valid_i && (op == OP_HALF);
    acc_en  = valid_i && (op == OP_ACC);
    fl_we   = '0;
    fl_val  = '0;
    av_clr  = '0;
    if (half_en && h_left) begin
      fl_we.az  = 1'b1;
      fl_we.an  = 1'b1;
      fl_we.v   = 1'b1;
      fl_we.vs  = h_ovf;
      fl_val.az = (h_res == '0);
      fl_val.an = h_res[HALF_W-1];
      fl_val.v  = h_ovf;
      fl_val.vs = 1'b1;
    end else if (acc_en) begin
      fl_we.az  = 1'b1;
      fl_we.an  = 1'b1;
      fl_val.az = a_zero;
      fl_val.an = a_neg;
      av_clr    = NUM_ACC'(1) << acc_sel_i;
    end
  end

  ishf_flag_regs #(.NUM_ACC(NUM_ACC)) u_flags (
    .clk(clk), .rst_n(rst_n), .we_i(fl_we), .val_i(fl_val),
    .av_clr_i(av_clr), .flags_o(fl_q), .av_o(flag_av_o)
  );

  // Result registers
  logic [HALF_W-1:0] half_q, half_d;
  logic [EXT_W-1:0]  ext_q, ext_d;
  logic [LO_W-1:0]   lo_q, lo_d;

  always_comb begin
    half_d = half_en ? h_res : half_q;
    ext_d  = acc_en  ? a_ext : ext_q;
    lo_d   = acc_en  ? a_lo  : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      ext_q  <= '0;
      lo_q   <= '0;
    end else begin
      half_q <= half_d;
      ext_q  <= ext_d;
      lo_q   <= lo_d;
    end
  end

  assign half_o    = half_q;
  assign acc_ext_o = ext_q;
  assign acc_lo_o  = lo_q;
  assign flag_az_o = fl_q.az;
  assign flag_an_o = fl_q.an;
  assign flag_v_o  = fl_q.v;
  assign flag_vs_o = fl_q.vs;

  p_v_needs_vs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v_o |-> flag_vs_o)
    else $error("p_v_needs_vs_r3");

  p_sat_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !op_acc_i && code > CODE_W'(HALF_W)) |=>
      (!flag_v_o || half_o == ($past(half_i[HALF_W-1]) ?
        {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}})))
    else $error("p_sat_sign_r3");

  p_left_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !op_acc_i && code > CODE_W'(HALF_W)) |=>
      (flag_az_o == (half_o == '0) && flag_an_o == half_o[HALF_W-1]))
    else $error("p_left_flags_r4");

  p_right_flags_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !op_acc_i && code <= CODE_W'(HALF_W)) |=>
      ($stable(flag_az_o) && $stable(flag_an_o) && $stable(flag_v_o) &&
       $stable(flag_vs_o) && $stable(flag_av_o)))
    else $error("p_right_flags_stable_r5");

  p_acc_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_acc_i) |=>
      (flag_an_o == acc_ext_o[EXT_W-1] &&
       flag_az_o == ({acc_ext_o, acc_lo_o} == ACC_W'(0)) &&
       $stable(flag_v_o) && $stable(flag_vs_o)))
    else $error("p_acc_flags_r8");

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(half_o) && $stable(acc_ext_o) && $stable(acc_lo_o)))
    else $error("p_idle_hold_r9");
endmodule

// File: tb/test_imm_shift_unit.sv
module test_imm_shift_unit;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, op_acc_i, acc_sel_i;
  logic [5:0]  imm_i;
  logic [15:0] half_i;
  logic [7:0]  acc_ext_i;
  logic [31:0] acc_lo_i;
  logic [15:0] half_o;
  logic [7:0]  acc_ext_o;
  logic [31:0] acc_lo_o;
  logic        flag_az_o, flag_an_o, flag_v_o, flag_vs_o;
  logic [1:0]  flag_av_o;

  int checks = 0;
  int failures = 0;

  // model state
  logic [15:0] m_half;
  logic [39:0] m_acc;
  logic        m_az, m_an, m_v, m_vs;

  always #(CLK_P/2) clk = ~clk;

  imm_shift_unit i_imm_shift_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_acc_i(op_acc_i),
    .acc_sel_i(acc_sel_i), .imm_i(imm_i), .half_i(half_i),
    .acc_ext_i(acc_ext_i), .acc_lo_i(acc_lo_i), .half_o(half_o),
    .acc_ext_o(acc_ext_o), .acc_lo_o(acc_lo_o), .flag_az_o(flag_az_o),
    .flag_an_o(flag_an_o), .flag_v_o(flag_v_o), .flag_vs_o(flag_vs_o),
    .flag_av_o(flag_av_o)
  );

  task automatic chk(string req, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "half_o", 40'(half_o), 40'(m_half));
    chk(req, "acc", {acc_ext_o, acc_lo_o}, m_acc);
    chk(req, "az", 40'(flag_az_o), 40'(m_az));
    chk(req, "an", 40'(flag_an_o), 40'(m_an));
    chk(req, "v", 40'(flag_v_o), 40'(m_v));
    chk(req, "vs", 40'(flag_vs_o), 40'(m_vs));
    chk(req, "av", 40'(flag_av_o), 40'(0));
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R10: half-word operation with model update
  task automatic half_op(string req, logic [15:0] d, logic [5:0] imm);
    int m = int'(imm[4:0]);
    valid_i = 1'b1; op_acc_i = 1'b0; imm_i = imm; half_i = d;
    if (m > 16) begin
      int s = 32 - m;
      int prod = int'($signed(d)) * (1 << s);
      if (prod > 32767 || prod < -32768) begin
        m_half = d[15] ? 16'h8000 : 16'h7FFF;
        m_v = 1'b1; m_vs = 1'b1;
      end else begin
        m_half = prod[15:0];
        m_v = 1'b0;
      end
      m_az = (m_half == 16'h0);
      m_an = m_half[15];
    end else begin
      m_half = 16'($signed(d) >>> m);
    end
    cycle();
    chk_all(req);
  endtask

  // R7 R8: accumulator operation
  task automatic acc_op(string req, logic [39:0] a, logic [5:0] imm, logic sel);
    valid_i = 1'b1; op_acc_i = 1'b1; imm_i = imm; acc_sel_i = sel;
    acc_ext_i = a[39:32]; acc_lo_i = a[31:0];
    m_acc = 40'($signed(a) >>> imm[4:0]);
    m_an = m_acc[39];
    m_az = (m_acc == 40'h0);
    cycle();
    chk_all(req);
  endtask

  task automatic test_reset_r1();
    rst_n = 1'b0;
    #1;
    m_half = '0; m_acc = '0; m_az = 0; m_an = 0; m_v = 0; m_vs = 0;
    chk_all("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cycle();
    chk_all("R1");
  endtask

  task automatic test_left_r2_r4();
    half_op("R2", 16'h0123, 6'd28);   // <<4 -> 0x1230
    half_op("R2", 16'hFFF0, 6'd28);   // negative, no ovf -> 0xFF00
    half_op("R4", 16'h0000, 6'd17);   // <<15 zero -> AZ
    half_op("R4", 16'h4000, 6'd30);   // <<2 -> ovf
  endtask

  task automatic test_overflow_r3();
    test_reset_r1();
    half_op("R3", 16'h4000, 6'd31);   // bit15 flips -> 7FFF
    half_op("R3", 16'h8001, 6'd31);   // negative -> 8000
    half_op("R3", 16'h2000, 6'd29);   // lost middle bit -> 7FFF
    half_op("R3", 16'hC000, 6'd31);   // 0x8000 exact, no ovf
  endtask

  task automatic test_sticky_r6();
    half_op("R6", 16'h7000, 6'd31);   // ovf sets V VS
    half_op("R6", 16'h0001, 6'd31);   // no ovf: V clear, VS stays
    chk("R6", "vs_kept", 40'(flag_vs_o), 40'(1));
    chk("R6", "v_clr", 40'(flag_v_o), 40'(0));
  endtask

  task automatic test_right_r5();
    half_op("R5", 16'h8000, 6'd16);   // all ones
    half_op("R5", 16'h8004, 6'd2);    // 0xE001
    half_op("R5", 16'h7FFF, 6'd16);   // zero
    half_op("R5", 16'h1234, 6'd0);    // identity
  endtask

  task automatic test_acc_r7_r8();
    acc_op("R7", 40'h80_00000000, 6'd4, 1'b0);
    acc_op("R7", 40'h7F_FFFFFFFF, 6'd31, 1'b1);
    acc_op("R8", 40'h00_0000000F, 6'd4, 1'b0);   // zero -> AZ
    acc_op("R8", 40'hFF_FFFFFFFF, 6'd31, 1'b1);  // stays -1, AN
    acc_op("R7", 40'h12_345678AB, 6'd0, 1'b0);
  endtask

  task automatic test_idle_r9();
    valid_i = 1'b0; op_acc_i = 1'b0; imm_i = 6'd31; half_i = 16'h7FFF;
    @(posedge clk); #1;
    chk_all("R9");
    op_acc_i = 1'b1; acc_ext_i = 8'h80; acc_lo_i = '0; imm_i = 6'd1;
    @(posedge clk); #1;
    chk_all("R9");
    @(negedge clk);
  endtask

  task automatic test_imm_msb_r10();
    half_op("R10", 16'h0123, 6'd28 | 6'h20);
    half_op("R10", 16'h8004, 6'd2 | 6'h20);
    acc_op("R10", 40'h80_00000000, 6'd8 | 6'h20, 1'b1);
  endtask

  task automatic test_isolation_r11();
    acc_op("R11", 40'h55_AAAA5555, 6'd1, 1'b0);
    half_op("R11", 16'h0F0F, 6'd3);
    chk("R11", "acc_kept", {acc_ext_o, acc_lo_o}, 40'h2A_D5552AAA);
    acc_op("R11", 40'h01_00000000, 6'd1, 1'b1);
    chk("R11", "half_kept", 40'(half_o), 40'h01E1);
  endtask

  initial begin
    #(CLK_P * 50000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    valid_i = 0; op_acc_i = 0; acc_sel_i = 0; imm_i = '0;
    half_i = '0; acc_ext_i = '0; acc_lo_i = '0;
    @(negedge clk);
    test_reset_r1();
    test_left_r2_r4();
    test_overflow_r3();
    test_sticky_r6();
    test_right_r5();
    test_acc_r7_r8();
    test_idle_r9();
    test_imm_msb_r10();
    test_isolation_r11();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule